// File: doc/BRIEF.md
# DVMA Page-Table Address Translator

This block turns a device's DMA request, made in device virtual address space, into a series of physical-address segments. A request carries a start address, a byte count and a direction flag. The block walks the request one 4 KB page at a time. For each page it reads one 32-bit page-table entry from memory through a fetch port, checks that entry, and hands the physical address and byte count of that piece to a downstream data mover.

The page table is flat and indexed by the virtual page number. Before the index is formed, the address is masked by a configurable DMA window, which clears the window's high address bits. A page whose entry is not marked valid ends the whole transfer. A write into a page that is not marked writeable also ends the whole transfer. In both cases the block reports a fault carrying the virtual address of the failing segment, and it emits nothing for that page or for any later page.

The request, fetch and segment interfaces all use valid/ready. A side that drops ready stalls the block, and the block holds its offered values steady until they are taken. The completion and fault outputs are plain one-cycle pulses with no handshake.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `pte_req_valid`, `seg_valid`, `xfer_done` and `xfer_fault` are all 0.
- R2: A request is taken only while the block is idle. While a transfer is in progress, `req_ready` stays 0 and a `req_valid` has no effect on the segments that are emitted.
- R3: The window start is all ones in bits 31 down to 24+`cfg_win_sel` and zero below them. For example, sel 0 gives 0xFF000000 and sel 7 gives 0x80000000. The entry address is (`cfg_base` << 4) + (((dva & ~window_start) >> 10) with bits 1:0 cleared), and it is taken modulo 2^32. `cfg_base` and `cfg_win_sel` are sampled when a request is taken.
- R4: Entry bit 1 means valid and bit 2 means writeable. The segment physical address is ((entry & 0x07FFFF00) << 4) | dva[11:0].
- R5: A transfer is split at 4 KB boundaries. Each segment length is min(4096 − dva[11:0], bytes remaining), and each following segment starts where the previous one ended.
- R6: An entry with bit 1 clear causes a one-cycle `xfer_fault` pulse, with `fault_dva` set to that segment's start address. That segment and every later one are not emitted, and `xfer_done` is not raised.
- R7: A write request whose entry has bit 2 clear faults in the same way as R6. A read of that same entry translates normally.
- R8: A request with a byte count of zero issues no fetch and produces `xfer_done` in the cycle after it is taken.
- R9: Only one entry fetch is outstanding at a time. `pte_req_valid` stays high with a stable `pte_req_addr` until `pte_req_ready` is seen. The response is a single-cycle `pte_rsp_valid`, which may arrive any number of cycles later.
- R10: While `seg_ready` is low, `seg_valid`, `seg_pa`, `seg_len` and `seg_write` hold their values.
- R11: `xfer_done` pulses in the cycle after the last segment is accepted, and the block is idle again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Page-table base value, shifted left by 4 to form the table address |
| cfg_win_sel | input | 3 | Window size select (16 MB << sel) |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_dva | input | 32 | Start device virtual address |
| req_len | input | 16 | Byte count |
| req_write | input | 1 | 1 = device writes memory |
| pte_req_valid | output | 1 | Entry fetch request |
| pte_req_ready | input | 1 | Memory accepts fetch |
| pte_req_addr | output | 32 | Entry address |
| pte_rsp_valid | input | 1 | Entry data returned (single cycle) |
| pte_rsp_data | input | 32 | Entry data |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Downstream takes segment |
| seg_pa | output | 32 | Segment physical address |
| seg_len | output | 13 | Segment byte count (1..4096) |
| seg_write | output | 1 | Direction of the segment |
| xfer_done | output | 1 | Transfer completed pulse |
| xfer_fault | output | 1 | Transfer aborted pulse |
| fault_dva | output | 32 | Virtual address of the aborted segment |

## Verification
The bench starts a transfer part-way into a page so that the first segment is short, then crosses two full pages and ends with a short tail. A design that computed the length from the start of the page, or let a segment cross a page boundary, would emit wrong lengths or physical addresses. Window selection is checked by placing different entries at the addresses that two window sizes would index. Taking the wrong mask or shift would return the wrong page number. Faults are injected mid-transfer and as write-protect hits, and both are compared against a read of the same page. A design that kept going after the bad page, faulted on reads, or reported the page's address rather than the segment's would be caught. Fetch stalls, response latency, output back-pressure and zero-length requests cover lost handshakes, duplicate fetches and a completion that never arrives.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EMIT
  } xl_state_e;
endpackage

// File: rtl/dvma_win_decode.sv
module dvma_win_decode #(
  parameter int AW        = 32,
  parameter int SEL_W     = 3,
  parameter int MIN_SHIFT = 24
) (
  input  logic [SEL_W-1:0] sel,
  output logic [AW-1:0]    win_start
);
  logic [AW-1:0] limit;

  // window start: ones above bit MIN_SHIFT+sel, zeros below
  always_comb begin
    limit     = AW'(1) << (MIN_SHIFT + int'(sel));
    win_start = ~(limit - AW'(1));
  end
endmodule

// File: rtl/dvma_seg_calc.sv
module dvma_seg_calc #(
  parameter int AW         = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [AW-1:0]       dva,
  input  logic [LEN_W-1:0]    remain,
  input  logic [AW-1:0]       base,
  input  logic [AW-1:0]       win_start,
  output logic [AW-1:0]       pte_addr,
  output logic [PAGE_SHIFT:0] seg_len
);
  localparam int            SEG_W     = PAGE_SHIFT + 1;
  localparam logic [SEG_W-1:0] PAGE_BYTES = SEG_W'(1) << PAGE_SHIFT;

  logic [AW-1:0]    masked;
  logic [SEG_W-1:0] to_end;

  always_comb begin
    masked   = dva & ~win_start;
    pte_addr = (base << 4) + ((masked >> (PAGE_SHIFT - 2)) & ~AW'(3));
    to_end   = PAGE_BYTES - SEG_W'(dva[PAGE_SHIFT-1:0]);
    if (LEN_W'(to_end) > remain) seg_len = SEG_W'(remain);
    else                         seg_len = to_end;
  end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check #(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [31:0]           pte,
  input  logic [PAGE_SHIFT-1:0] offset,
  input  logic                  is_write,
  output logic                  ok,
  output logic [AW-1:0]         pa
);
  localparam logic [31:0] PPN_MASK = 32'h07FF_FF00;

  logic pte_valid, pte_writable;
  logic unused_pte_bits;

  assign pte_valid       = pte[1];
  assign pte_writable    = pte[2];
  assign unused_pte_bits = ^{pte[31:27], pte[7:3], pte[0]};

  always_comb begin
    ok = pte_valid && (!is_write || pte_writable);
    pa = AW'((pte & PPN_MASK) << 4) | AW'(offset);
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int AW            = 32,
  parameter int LEN_W         = 16,
  parameter int PAGE_SHIFT    = 12,
  parameter int SEL_W         = 3,
  parameter int WIN_MIN_SHIFT = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         cfg_base,
  input  logic [SEL_W-1:0]      cfg_win_sel,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_dva,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  req_write,
  output logic                  pte_req_valid,
  input  logic                  pte_req_ready,
  output logic [AW-1:0]         pte_req_addr,
  input  logic                  pte_rsp_valid,
  input  logic [31:0]           pte_rsp_data,
  output logic                  seg_valid,
  input  logic                  seg_ready,
  output logic [AW-1:0]         seg_pa,
  output logic [PAGE_SHIFT:0]   seg_len,
  output logic                  seg_write,
  output logic                  xfer_done,
  output logic                  xfer_fault,
  output logic [AW-1:0]         fault_dva
);
  localparam int SEG_W = PAGE_SHIFT + 1;

  xl_state_e        state;
  logic [AW-1:0]    cur_dva;
  logic [LEN_W-1:0] remain;
  logic             wr_q;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    win_q;
  logic [AW-1:0]    pa_q;
  logic [SEG_W-1:0] len_q;
  logic             done_q;
  logic             fault_q;
  logic [AW-1:0]    fdva_q;

  logic [AW-1:0]    win_live;
  logic [AW-1:0]    pte_addr_c;
  logic [SEG_W-1:0] seg_len_c;
  logic             pte_ok;
  logic [AW-1:0]    pa_c;

  dvma_win_decode #(.AW(AW), .SEL_W(SEL_W), .MIN_SHIFT(WIN_MIN_SHIFT)) u_win (
    .sel       (cfg_win_sel),
    .win_start (win_live)
  );

  dvma_seg_calc #(.AW(AW), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_seg (
    .dva       (cur_dva),
    .remain    (remain),
    .base      (base_q),
    .win_start (win_q),
    .pte_addr  (pte_addr_c),
    .seg_len   (seg_len_c)
  );

  dvma_pte_check #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
    .pte      (pte_rsp_data),
    .offset   (cur_dva[PAGE_SHIFT-1:0]),
    .is_write (wr_q),
    .ok       (pte_ok),
    .pa       (pa_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_dva <= '0;
      remain  <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      win_q   <= '0;
      pa_q    <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      fdva_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_len == '0) begin
              done_q <= 1'b1;
            end else begin
              cur_dva <= req_dva;
              remain  <= req_len;
              wr_q    <= req_write;
              base_q  <= cfg_base;
              win_q   <= win_live;
              state   <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (pte_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (pte_rsp_valid) begin
            if (pte_ok) begin
              pa_q  <= pa_c;
              len_q <= seg_len_c;
              state <= ST_EMIT;
            end else begin
              fault_q <= 1'b1;
              fdva_q  <= cur_dva;
              state   <= ST_IDLE;
            end
          end
        end
        ST_EMIT: begin
          if (seg_ready) begin
            cur_dva <= cur_dva + AW'(len_q);
            remain  <= remain - LEN_W'(len_q);
            if (remain == LEN_W'(len_q)) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state  <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign pte_req_valid = (state == ST_FETCH);
  assign pte_req_addr  = pte_addr_c;
  assign seg_valid     = (state == ST_EMIT);
  assign seg_pa        = pa_q;
  assign seg_len       = len_q;
  assign seg_write     = wr_q;
  assign xfer_done     = done_q;
  assign xfer_fault    = fault_q;
  assign fault_dva     = fdva_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!pte_req_valid && !seg_valid)); // R2
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_req_valid && !pte_req_ready) |=> (pte_req_valid && $stable(pte_req_addr))); // R9
  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_req_valid && pte_req_ready) |=> !pte_req_valid); // R9
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_pa) && $stable(seg_len) && $stable(seg_write))); // R10
  AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> ((seg_len != '0) &&
      (({2'b00, seg_pa[PAGE_SHIFT-1:0]} + {1'b0, seg_len}) <= ((PAGE_SHIFT+2)'(1) << PAGE_SHIFT)))); // R5
  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_fault)); // R6
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fault |=> !xfer_fault); // R6
endmodule

// File: tb/tb_dvma_xlate.sv
`timescale 1ns/1ps
module tb_dvma_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_win_sel = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_dva = '0;
  logic [15:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        pte_req_valid;
  logic        pte_req_ready;
  logic [31:0] pte_req_addr;
  logic        pte_rsp_valid;
  logic [31:0] pte_rsp_data;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [31:0] seg_pa;
  logic [12:0] seg_len;
  logic        seg_write;
  logic        xfer_done;
  logic        xfer_fault;
  logic [31:0] fault_dva;

  int n_checks = 0;
  int n_fail   = 0;
  int fetches  = 0;
  int rsp_lat  = 0;
  bit stall_fetch = 0;
  logic [31:0] pte_mem [int unsigned];

  always #10 clk = ~clk;

  dvma_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_win_sel(cfg_win_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_dva(req_dva),
    .req_len(req_len), .req_write(req_write),
    .pte_req_valid(pte_req_valid), .pte_req_ready(pte_req_ready),
    .pte_req_addr(pte_req_addr), .pte_rsp_valid(pte_rsp_valid),
    .pte_rsp_data(pte_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_pa(seg_pa),
    .seg_len(seg_len), .seg_write(seg_write),
    .xfer_done(xfer_done), .xfer_fault(xfer_fault), .fault_dva(fault_dva)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] win_of(input logic [2:0] sel);
    logic [32:0] lim;
    lim = 33'h1 << (24 + int'(sel));
    return ~(lim[31:0] - 32'h1);
  endfunction

  function automatic logic [31:0] ent_addr(input logic [31:0] base, input logic [2:0] sel,
                                           input logic [31:0] dva);
    logic [31:0] m;
    m = dva & ~win_of(sel);
    return (base << 4) + ((m >> 10) & ~32'h3);
  endfunction

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (pte_mem.exists(a)) return pte_mem[a];
    return 32'h0;
  endfunction

  task automatic map_page(input logic [2:0] sel, input logic [31:0] dva, input logic [31:0] pte);
    pte_mem[ent_addr(cfg_base, sel, dva)] = pte;
  endtask

  // memory model for the entry fetch port (R9)
  initial begin
    bit          pend = 0;
    int          dly  = 0;
    int          tick = 0;
    logic [31:0] paddr = '0;
    logic [31:0] held  = '0;
    bit          stalled = 0;
    pte_req_ready = 1'b0;
    pte_rsp_valid = 1'b0;
    pte_rsp_data  = '0;
    forever begin
      @(negedge clk);
      pte_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          pte_rsp_valid = 1'b1;
          pte_rsp_data  = lookup(paddr);
          pend = 0;
        end else dly--;
      end
      pte_req_ready = stall_fetch ? tick[0] : 1'b1;
      tick++;
      if (pte_req_valid) begin
        if (pend) check_eq("R9", "second fetch while one outstanding", 32'h1, 32'h0);
        if (stalled) check_eq("R9", "fetch addr held during stall", pte_req_addr, held);
        if (pte_req_ready) begin
          pend = 1; dly = rsp_lat; paddr = pte_req_addr; fetches++; stalled = 0;
        end else begin
          stalled = 1; held = pte_req_addr;
        end
      end else stalled = 0;
    end
  end

  // run one transfer; expected values computed from R3..R7
  task automatic run_xfer(input logic [31:0] dva, input int len, input bit wr,
                          input bit bp, input bit poke, input string tag);
    logic [31:0] epa[$];
    int          elen[$];
    bit          efault = 0;
    logic [31:0] efdva = '0;
    logic [31:0] cur = dva;
    int          rem = len;
    int          idx = 0;
    int          cyc = 0;
    int          last_fire = -1;
    bit          got_done = 0, got_fault = 0;
    bit          hold = 0;
    logic [31:0] hold_pa = '0;
    logic [12:0] hold_len = '0;
    while (rem > 0) begin
      logic [31:0] p;
      int te, sl;
      p = lookup(ent_addr(cfg_base, cfg_win_sel, cur));
      if (!p[1] || (wr && !p[2])) begin efault = 1; efdva = cur; break; end
      te = 4096 - int'(cur[11:0]);
      sl = (rem < te) ? rem : te;
      epa.push_back(((p & 32'h07FF_FF00) << 4) | {20'h0, cur[11:0]});
      elen.push_back(sl);
      cur += sl; rem -= sl;
    end
    @(negedge clk);
    req_dva = dva; req_len = 16'(len); req_write = wr; req_valid = 1'b1;
    check_eq("R2", {tag, " req_ready when idle"}, {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!got_done && !got_fault && cyc < 3000) begin
      if (xfer_done) begin
        got_done = 1;
        check_eq("R11", {tag, " done one cycle after last segment"}, cyc, last_fire + 1);
      end
      if (xfer_fault) begin
        got_fault = 1;
        check_eq("R6", {tag, " fault_dva"}, fault_dva, efdva);
      end
      if (!got_done && !got_fault) begin
        check_eq("R2", {tag, " req_ready low while busy"}, {31'h0, req_ready}, 32'h0);
        if (poke) begin req_valid = 1'b1; req_dva = 32'hDEAD_0000; req_len = 16'h10; end
      end else req_valid = 1'b0;
      if (hold) begin
        check_eq("R10", {tag, " seg held"}, {seg_pa[30:0], seg_valid},
                 {hold_pa[30:0], 1'b1});
        check_eq("R10", {tag, " seg_len held"}, 32'(seg_len), 32'(hold_len));
      end
      seg_ready = bp ? (cyc % 3 == 2) : 1'b1;
      hold = 0;
      if (seg_valid) begin
        if (seg_ready) begin
          if (idx < epa.size()) begin
            check_eq("R4", {tag, " seg_pa"}, seg_pa, epa[idx]);
            check_eq("R5", {tag, " seg_len"}, 32'(seg_len), elen[idx]);
            check_eq("R4", {tag, " seg_write"}, {31'h0, seg_write}, {31'h0, wr});
          end else check_eq("R6", {tag, " extra segment"}, 32'(idx), 32'(epa.size()));
          idx++; last_fire = cyc;
        end else begin
          hold = 1; hold_pa = seg_pa; hold_len = seg_len;
        end
      end
      @(negedge clk);
      cyc++;
    end
    seg_ready = 1'b0; req_valid = 1'b0;
    check_eq("R5", {tag, " segment count"}, 32'(idx), 32'(epa.size()));
    check_eq("R6", {tag, " fault seen"}, {31'h0, got_fault}, {31'h0, efault});
    check_eq("R11", {tag, " done seen"}, {31'h0, got_done}, {31'h0, !efault});
  endtask

  task automatic test_reset();
    check_eq("R1", "req_ready", {31'h0, req_ready}, 32'h1);
    check_eq("R1", "pte_req_valid", {31'h0, pte_req_valid}, 32'h0);
    check_eq("R1", "seg_valid", {31'h0, seg_valid}, 32'h0);
    check_eq("R1", "done/fault", {30'h0, xfer_done, xfer_fault}, 32'h0);
  endtask

  task automatic test_single_page();
    cfg_base = 32'h0010_0000; cfg_win_sel = 3'd7;
    map_page(3'd7, 32'h8000_0000, 32'h0012_3406);
    run_xfer(32'h8000_0200, 256, 1'b0, 1'b0, 1'b0, "single R3 R4");
  endtask

  task automatic test_cross_pages();
    cfg_base = 32'h0020_0000; cfg_win_sel = 3'd7;
    map_page(3'd7, 32'h8004_0000, 32'h0000_1106);
    map_page(3'd7, 32'h8004_1000, 32'h0033_3306);
    map_page(3'd7, 32'h8004_2000, 32'h0044_5506);
    map_page(3'd7, 32'h8004_3000, 32'h0066_7706);
    rsp_lat = 3; stall_fetch = 1;
    run_xfer(32'h8004_0F00, 10000, 1'b1, 1'b1, 1'b0, "cross R5 R9 R10");
    rsp_lat = 0; stall_fetch = 0;
  endtask

  task automatic test_window_sel();
    cfg_base = 32'h0030_0000;
    map_page(3'd0, 32'hFF12_3000, 32'h0011_1106);
    map_page(3'd7, 32'hFF12_3000, 32'h0022_2206);
    cfg_win_sel = 3'd0;
    run_xfer(32'hFF12_3400, 128, 1'b0, 1'b0, 1'b0, "win sel0 R3");
    cfg_win_sel = 3'd7;
    run_xfer(32'hFF12_3400, 128, 1'b0, 1'b0, 1'b0, "win sel7 R3");
  endtask

  task automatic test_invalid();
    cfg_base = 32'h0040_0000; cfg_win_sel = 3'd7;
    map_page(3'd7, 32'h8001_0000, 32'h0001_0006);
    map_page(3'd7, 32'h8001_1000, 32'h0001_1104);
    map_page(3'd7, 32'h8001_2000, 32'h0001_2206);
    rsp_lat = 1;
    run_xfer(32'h8001_0000, 32'h2800, 1'b0, 1'b0, 1'b0, "invalid R6");
    rsp_lat = 0;
  endtask

  task automatic test_write_protect();
    cfg_base = 32'h0050_0000; cfg_win_sel = 3'd3;
    map_page(3'd3, 32'hF800_5000, 32'h0055_5502);
    run_xfer(32'hF800_5010, 64, 1'b1, 1'b0, 1'b0, "wp write R7");
    run_xfer(32'hF800_5010, 64, 1'b0, 1'b0, 1'b0, "wp read R7");
  endtask

  task automatic test_zero_len();
    int f0;
    f0 = fetches;
    run_xfer(32'h8000_0000, 0, 1'b0, 1'b0, 1'b0, "zero R8");
    repeat (3) @(negedge clk);
    check_eq("R8", "no fetch for zero length", 32'(fetches), 32'(f0));
  endtask

  task automatic test_busy_ignored();
    cfg_base = 32'h0060_0000; cfg_win_sel = 3'd7;
    map_page(3'd7, 32'h8007_0000, 32'h0007_0006);
    map_page(3'd7, 32'h8007_1000, 32'h0007_1006);
    rsp_lat = 2;
    run_xfer(32'h8007_0800, 4096, 1'b0, 1'b1, 1'b1, "busy R2");
    rsp_lat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single_page();
    test_cross_pages();
    test_window_sel();
    test_invalid();
    test_write_protect();
    test_zero_len();
    test_busy_ignored();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule